// File: doc/BRIEF.md
# Fault-Campaign Event Recorder

This block sits beside an emulated design during a fault-injection run. On every emulation tick it compares the design's outputs with the stored reference outputs. It also watches an end-of-vectors strobe and five general event inputs. Every tick that raises at least one condition produces exactly one record. The record holds an 8-bit condition mask and the 64-bit cycle number of that tick. Records go into a queue of parameterised depth, and software reads the queue out one record at a time once the run is over.

A per-condition stop mask halts the run in hardware. Once a selected condition fires, the halt output rises and the cycle counter stops, so the remaining vectors are not emulated. A start pulse opens a new run. It clears the counter, the halt state and the queue.

The mask layout is fixed:

| Bit | Meaning |
|-----|---------|
| 0 | Output mismatch |
| 1 | End of vectors |
| 2 to 6 | Event inputs 0 to 4 |
| 7 | Queue overflow |

Top module: `fi_event_log`

## Requirements
- R1: After reset, halt_o is 0, rd_valid_o is 0, and the first read returns an empty response.
- R2: During an active run, a tick with dut_out_i different from gold_out_i records mask bit 0.
- R3: Within one tick, vec_end_i sets mask bit 1 and ext_evt_i[k] sets mask bit 2+k. All conditions of that tick share one record.
- R4: A record's cycle stamp equals the number of ticks accepted since the last start pulse. The first tick has stamp 0.
- R5: These add no record: a tick with no condition, a cycle with emu_tick_i low, and any cycle outside an active run.
- R6: If any raised mask bit is also set in stop_mask_i, halt_o is 1 from the next cycle on. It stays 1 until the next start pulse, and later ticks add no record and do not advance the stamp.
- R7: With the queue full, a further record is dropped and mask bit 7 is set in the newest stored record. If stop_mask_i[7] is set, the drop also halts the run as in R6.
- R8: A one-cycle rd_req_i pops the oldest record. In the next cycle rd_valid_o is 1 with rd_mask_o and rd_cycle_o. If the queue was empty, rd_empty_o is 1 instead.
- R9: run_start_i empties the queue, clears the stamp to 0 and clears halt. A tick in the same cycle as run_start_i is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_start_i | input | 1 | Start-of-run pulse |
| emu_tick_i | input | 1 | One pulse per emulated cycle |
| dut_out_i | input | DATA_W | Outputs of the design under test |
| gold_out_i | input | DATA_W | Reference outputs for the same cycle |
| vec_end_i | input | 1 | Last-vector strobe |
| ext_evt_i | input | 5 | Additional event inputs (mask bits 2..6) |
| stop_mask_i | input | 8 | Conditions that halt the run |
| halt_o | output | 1 | Run halted by a stop condition |
| rd_req_i | input | 1 | Pop one record |
| rd_valid_o | output | 1 | Read response valid |
| rd_empty_o | output | 1 | Response carries no record |
| rd_mask_o | output | 8 | Condition mask of the popped record |
| rd_cycle_o | output | 64 | Cycle stamp of the popped record |

## Verification
The bench targets these corner cases:

- **Several conditions on one tick.** A design that wrote one record per condition would leave extra records in the queue.
- **Ticks after a halt.** A counter that did not freeze would show up as skewed stamps. A gate that leaked would show up as records made after the stop.
- **Overflow with a full queue.** A design that wrapped would overwrite the oldest record. A design that forgot the sticky bit would return a clean last record.
- **A start pulse over a non-empty queue.** A stale queue would leak records from the previous run into the new one.
- **Random runs with sparse stop masks.** These compare every drained record and the halt level on each cycle against a bench model.

// File: rtl/fi_event_pkg.sv
package fi_event_pkg;
  localparam int unsigned MASK_W  = 8;
  localparam int unsigned CYC_W   = 64;
  localparam int unsigned EXT_W   = 5;
  localparam int unsigned BIT_MIS = 0;
  localparam int unsigned BIT_END = 1;
  localparam int unsigned BIT_EXT = 2;
  localparam int unsigned BIT_OVF = 7;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [CYC_W-1:0]  cycle;
  } evt_rec_t;
endpackage

// File: rtl/fi_evt_detect.sv
module fi_evt_detect
  import fi_event_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              qual_i,
  input  logic [DATA_W-1:0] dut_i,
  input  logic [DATA_W-1:0] gold_i,
  input  logic              vec_end_i,
  input  logic [EXT_W-1:0]  ext_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] diff;
  logic [MASK_W-1:0] raw;

  // per-bit compare, reduced below
  for (genvar g = 0; g < DATA_W; g++) begin : g_cmp
    assign diff[g] = dut_i[g] ^ gold_i[g];
  end

  always_comb begin
    raw                          = '0;
    raw[BIT_MIS]                 = |diff;
    raw[BIT_END]                 = vec_end_i;
    raw[BIT_EXT +: EXT_W]        = ext_i;
    mask_o = qual_i ? raw : '0;
    hit_o  = |mask_o;
  end
endmodule

// File: rtl/fi_run_ctl.sv
module fi_run_ctl
  import fi_event_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_start_i,
  input  logic             tick_i,
  input  logic             stop_hit_i,
  output logic             qual_o,
  output logic [CYC_W-1:0] cycle_o,
  output logic             halt_o
);
  logic             active_q, halt_q;
  logic [CYC_W-1:0] cnt_q;

  assign qual_o  = active_q && tick_i && !run_start_i;
  assign cycle_o = cnt_q;
  assign halt_o  = halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      halt_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (run_start_i) begin
      active_q <= 1'b1;
      halt_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (stop_hit_i) begin
        active_q <= 1'b0;
        halt_q   <= 1'b1;
      end
    end
  end

  p_halt_next_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual_o && stop_hit_i) |=> halt_q);
  p_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !run_start_i) |=> ($stable(cnt_q) && halt_q));
  p_start_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_start_i |=> (cnt_q == '0 && !halt_q));
endmodule

// File: rtl/fi_evt_queue.sv
module fi_evt_queue
  import fi_event_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     flush_i,
  input  logic     push_i,
  input  evt_rec_t rec_i,
  output logic     drop_o,
  input  logic     rd_req_i,
  output logic     rd_valid_o,
  output logic     rd_empty_o,
  output evt_rec_t rd_rec_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  evt_rec_t      mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, last_idx;
  logic [CW-1:0] cnt_q;
  logic          pop, push_ok, full;
  evt_rec_t      rd_rec_q;
  logic          rd_valid_q, rd_empty_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt_q == FULL_CNT);
  assign pop      = rd_req_i && (cnt_q != '0) && !flush_i;
  assign push_ok  = push_i && !flush_i && (!full || pop);
  assign drop_o   = push_i && !flush_i && full && !pop;
  assign last_idx = (wr_ptr_q == '0) ? LAST_IDX : wr_ptr_q - 1'b1;

  assign rd_valid_o = rd_valid_q;
  assign rd_empty_o = rd_empty_q;
  assign rd_rec_o   = rd_rec_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= rec_i;
    if (drop_o)  mem_q[last_idx].mask[BIT_OVF] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      rd_ptr_q   <= '0;
      cnt_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_empty_q <= 1'b0;
      rd_rec_q   <= '0;
    end else begin
      rd_valid_q <= rd_req_i;
      rd_empty_q <= rd_req_i && !pop;
      if (pop) rd_rec_q <= mem_q[rd_ptr_q];
      else if (rd_req_i) rd_rec_q <= '0;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
        cnt_q    <= '0;
      end else begin
        if (push_ok) wr_ptr_q <= inc(wr_ptr_q);
        if (pop)     rd_ptr_q <= inc(rd_ptr_q);
        cnt_q <= cnt_q + CW'(push_ok) - CW'(pop);
      end
    end
  end

  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  p_rd_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);
  p_rd_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && cnt_q == '0) |=> rd_empty_o);
  p_drop_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/fi_event_log.sv
module fi_event_log
  import fi_event_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_start_i,
  input  logic              emu_tick_i,
  input  logic [DATA_W-1:0] dut_out_i,
  input  logic [DATA_W-1:0] gold_out_i,
  input  logic              vec_end_i,
  input  logic [4:0]        ext_evt_i,
  input  logic [7:0]        stop_mask_i,
  output logic              halt_o,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic              rd_empty_o,
  output logic [7:0]        rd_mask_o,
  output logic [63:0]       rd_cycle_o
);
  logic              qual, hit, drop, stop_hit;
  logic [MASK_W-1:0] mask;
  logic [CYC_W-1:0]  cycle;
  evt_rec_t          rec, rd_rec;

  fi_evt_detect #(.DATA_W(DATA_W)) u_detect (
    .qual_i   (qual),
    .dut_i    (dut_out_i),
    .gold_i   (gold_out_i),
    .vec_end_i(vec_end_i),
    .ext_i    (ext_evt_i),
    .mask_o   (mask),
    .hit_o    (hit)
  );

  assign stop_hit = (|(mask & stop_mask_i)) || (drop && stop_mask_i[BIT_OVF]);

  fi_run_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_start_i(run_start_i),
    .tick_i     (emu_tick_i),
    .stop_hit_i (stop_hit),
    .qual_o     (qual),
    .cycle_o    (cycle),
    .halt_o     (halt_o)
  );

  assign rec.mask  = mask;
  assign rec.cycle = cycle;

  fi_evt_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (run_start_i),
    .push_i    (hit),
    .rec_i     (rec),
    .drop_o    (drop),
    .rd_req_i  (rd_req_i),
    .rd_valid_o(rd_valid_o),
    .rd_empty_o(rd_empty_o),
    .rd_rec_o  (rd_rec)
  );

  assign rd_mask_o  = rd_rec.mask;
  assign rd_cycle_o = rd_rec.cycle;

  p_halt_no_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !hit);
  p_start_no_push_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_start_i |-> !hit);
endmodule

// File: tb/fi_event_log_tb_top.sv
module fi_event_log_tb_top;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;

  logic clk = 0, rst_ni = 0;
  logic run_start = 0, tick = 0, vend = 0, rd_req = 0;
  logic [DATA_W-1:0] dut_o = 0, gold_o = 0;
  logic [4:0] ext = 0;
  logic [7:0] stop = 0;
  logic halt, rd_valid, rd_empty;
  logic [7:0] rd_mask;
  logic [63:0] rd_cycle;

  int n_chk = 0, n_err = 0;

  // bench model
  logic [7:0]  m_mask [DEPTH];
  logic [63:0] m_cyc  [DEPTH];
  int          m_n = 0;
  logic        m_act = 0, m_halt = 0;
  logic [63:0] m_cnt = 0;

  always #2 clk = ~clk;

  fi_event_log #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .run_start_i(run_start), .emu_tick_i(tick),
    .dut_out_i(dut_o), .gold_out_i(gold_o), .vec_end_i(vend), .ext_evt_i(ext),
    .stop_mask_i(stop), .halt_o(halt), .rd_req_i(rd_req), .rd_valid_o(rd_valid),
    .rd_empty_o(rd_empty), .rd_mask_o(rd_mask), .rd_cycle_o(rd_cycle)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mask();
    logic [7:0] m;
    m = {1'b0, ext, vend, dut_o != gold_o};
    return m;
  endfunction

  // one clock with current inputs; model advances at the edge
  task automatic cyc();
    logic [7:0] m;
    logic ovf;
    @(posedge clk);
    ovf = 0;
    if (run_start) begin
      m_n = 0; m_cnt = 0; m_act = 1; m_halt = 0;
    end else if (m_act && tick) begin
      m = exp_mask();
      if (m != 0) begin
        if (m_n < DEPTH) begin
          m_mask[m_n] = m; m_cyc[m_n] = m_cnt; m_n++;
        end else begin
          m_mask[DEPTH-1] |= 8'h80; ovf = 1;
        end
      end
      m_cnt++;
      if ((m & stop) != 0 || (ovf && stop[7])) begin
        m_act = 0; m_halt = 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    run_start = 0; tick = 0; vend = 0; ext = 0; dut_o = 0; gold_o = 0;
  endtask

  task automatic start_run(input logic [7:0] sm);
    idle_in(); stop = sm; run_start = 1; cyc(); run_start = 0;
  endtask

  task automatic step(input logic t, input logic mis, input logic ve, input logic [4:0] ex);
    tick = t; gold_o = DATA_W'($urandom);
    dut_o = mis ? gold_o ^ DATA_W'(16'h1 << ($urandom % DATA_W)) : gold_o;
    vend = ve; ext = ex;
    cyc();
    chk("R6 halt", halt, m_halt);
    idle_in();
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < DEPTH + 2; k++) begin
      rd_req = 1; @(posedge clk); @(negedge clk); rd_req = 0;
      chk({tag, " R8 valid"}, rd_valid, 1);
      if (m_n == 0) begin
        chk({tag, " R8 empty"}, rd_empty, 1);
        break;
      end
      chk({tag, " R8 notempty"}, rd_empty, 0);
      chk({tag, " R3 mask"}, rd_mask, m_mask[0]);
      chk({tag, " R4 cycle"}, rd_cycle, m_cyc[0]);
      for (int j = 1; j < DEPTH; j++) begin
        m_mask[j-1] = m_mask[j]; m_cyc[j-1] = m_cyc[j];
      end
      m_n--;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2741));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 halt", halt, 0);
    chk("R1 valid", rd_valid, 0);
    drain("R1");

    // R2 R3 R4 R5 directed
    start_run(8'h00);
    step(1, 0, 0, 5'h00);            // cycle 0, quiet (R5)
    step(1, 0, 0, 5'h00);            // cycle 1
    step(0, 1, 1, 5'h1f);            // no tick: ignored (R5)
    step(1, 1, 0, 5'h00);            // cycle 2, mismatch (R2)
    step(1, 1, 1, 5'h15);            // cycle 3, bundled (R3)
    chk("R5 count", m_n, 2);
    drain("R2");

    // R6 stop on mismatch, later ticks ignored
    start_run(8'h01);
    step(1, 0, 0, 5'h02);
    step(1, 1, 0, 5'h00);
    step(1, 1, 1, 5'h1f);
    step(1, 0, 1, 5'h00);
    chk("R6 halted", halt, 1);
    drain("R6");

    // R7 overflow without stop, then with stop on bit 7
    start_run(8'h00);
    for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 0, 5'h01);
    chk("R7 nohalt", halt, 0);
    drain("R7a");
    start_run(8'h80);
    for (int i = 0; i < DEPTH + 3; i++) step(1, 0, 1, 5'h00);
    chk("R7 halt", halt, 1);
    drain("R7b");

    // R9 start flushes queue, tick with start ignored
    start_run(8'h00);
    step(1, 1, 0, 5'h00);
    step(1, 1, 0, 5'h00);
    stop = 8'h00; run_start = 1; tick = 1; ext = 5'h04; cyc(); idle_in();
    chk("R9 halt", halt, 0);
    step(1, 0, 0, 5'h08);            // stamp 0 after restart
    drain("R9");

    // random runs
    for (int r = 0; r < 6; r++) begin
      start_run(($urandom % 3 == 0) ? (8'h1 << ($urandom % 8)) : 8'h00);
      for (int i = 0; i < 60; i++)
        step($urandom % 4 != 0, $urandom % 8 == 0, i == 59,
             {($urandom % 16 == 0), ($urandom % 16 == 0), ($urandom % 16 == 0),
              ($urandom % 16 == 0), ($urandom % 16 == 0)});
      drain("rand R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule